// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter assembled from identical narrow slices, four bits each by default, chained into one wide counter. Each slice can be cleared at once by an active-low clear that does not wait for the clock. It can also be preset from parallel data by an active-low load strobe sampled on the rising clock edge. Two count enables must both be high for the counter to advance. The "gate" enable stalls the counter. The "carry" enable also qualifies the terminal-count flag, so several counters can be chained.

Inside the wrapper, the carry enable of each stage is computed in look-ahead form. It is the external carry enable ANDed with the all-ones flags of every lower stage, so no stage waits for a ripple through the stages between. The wrapper's terminal-count output is the flag of the last stage. It goes high for one count state when the whole counter is all ones and the carry enable is high, and can feed the carry enable of a further counter. All pins are plain control and data levels; the block has no stream interface and applies no back-pressure.

Top module: `cascade_counter`

## Requirements
- R1: Apart from the clear, `count` changes only on a rising edge of `clk`. Input changes between edges leave it unchanged.
- R2: While `clr_n` is 0, `count` is 0 immediately, without waiting for a clock edge. The clear overrides load and both enables.
- R3: With `load_n` = 0 at a rising edge, `count` takes `load_val`, whatever the levels of `gate_en` and `carry_en`.
- R4: With `load_n` = 1 and both `gate_en` and `carry_en` = 1, `count` increments by one at each rising edge. It wraps from all ones (255 at default parameters) to 0.
- R5: With `load_n` = 1 and either enable 0, `count` holds its value.
- R6: `carry_out` = 1 exactly when `carry_en` = 1 and `count` is all ones. It follows `carry_en` without a clock edge.
- R7: A stage above the lowest advances only on an edge where every lower stage is all ones. For example, 0x0F steps to 0x10, and 0x10 steps to 0x11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| gate_en | input | 1 | Count enable that does not qualify the terminal-count flag |
| carry_en | input | 1 | Count enable that also qualifies the terminal-count flag |
| load_val | input | SLICE_W*STAGES | Parallel preset data |
| count | output | SLICE_W*STAGES | Current count |
| carry_out | output | 1 | Terminal count, high when `carry_en` is high and `count` is all ones |

## Verification
Random cycles mix loads, both enables and all four enable combinations. Comparing against a wide integer model separates the load priority from plain counting and holding. Directed presets just below the slice boundary (0x0F) and at the top (0xFF) show whether the look-ahead carries into the upper slice and whether the counter wraps. Dropping `carry_en` while at all ones separates the combinational gating of `carry_out` from the count value. A clear raised in the middle of a cycle, with load and both enables active, shows that the clear acts before the next edge and overrides everything else.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } slice_op_t;

  function automatic slice_op_t pick_op(input logic load_n,
                                        input logic gate_en,
                                        input logic carry_en);
    if (!load_n)                  return OP_LOAD;
    else if (gate_en && carry_en) return OP_STEP;
    else                          return OP_HOLD;
  endfunction
endpackage

// File: rtl/ctr_slice.sv
module ctr_slice
  import ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         gate_en,
  input  logic         carry_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         full,
  output logic         tc
);
  slice_op_t op;

  assign op   = pick_op(load_n, gate_en, carry_en);
  assign full = &q;
  assign tc   = carry_en & full;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      case (op)
        OP_LOAD: q <= din;
        OP_STEP: q <= q + W'(1);
        default: q <= q;
      endcase
    end
  end

  // R2: q stays zero for as long as the clear is held
  p_clear_zero_r2: assert property (@(posedge clk) !clr_n |-> q == '0);

  // R3: a load takes the data regardless of the enables
  p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  // R4: both enables with no load advance by one, modulo 2^W
  p_step_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && gate_en && carry_en) |=> q == $past(q) + W'(1));

  // R5: otherwise the slice holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(gate_en && carry_en)) |=> $stable(q));

  // R6: terminal count never appears without the carry enable
  p_tc_gate_r6: assert property (@(posedge clk) disable iff (!clr_n)
    tc |-> carry_en);
endmodule

// File: rtl/ctr_carry_net.sv
module ctr_carry_net #(
  parameter int STAGES = 2
) (
  input  logic              carry_en,
  input  logic [STAGES-1:0] full,
  output logic [STAGES-1:0] stage_en
);
  for (genvar i = 0; i < STAGES; i++) begin : g_en
    if (i == 0) begin : g_base
      assign stage_en[i] = carry_en;
    end else begin : g_up
      assign stage_en[i] = carry_en & (&full[i-1:0]);
    end
  end
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int SLICE_W = 4,
  parameter int STAGES  = 2,
  localparam int TOTAL_W = SLICE_W * STAGES
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               gate_en,
  input  logic               carry_en,
  input  logic [TOTAL_W-1:0] load_val,
  output logic [TOTAL_W-1:0] count,
  output logic               carry_out
);
  logic [STAGES-1:0] full_v;
  logic [STAGES-1:0] tc_v;
  logic [STAGES-1:0] stage_en;

  ctr_carry_net #(.STAGES(STAGES)) u_carry (
    .carry_en (carry_en),
    .full     (full_v),
    .stage_en (stage_en)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_slice
    ctr_slice #(.W(SLICE_W)) u_slice (
      .clk      (clk),
      .clr_n    (clr_n),
      .load_n   (load_n),
      .gate_en  (gate_en),
      .carry_en (stage_en[s]),
      .din      (load_val[s*SLICE_W +: SLICE_W]),
      .q        (count[s*SLICE_W +: SLICE_W]),
      .full     (full_v[s]),
      .tc       (tc_v[s])
    );
    if (s < STAGES - 1) begin : g_link
      // R7: a lower stage's terminal count is the next stage's carry enable
      p_link_r7: assert property (@(posedge clk) disable iff (!clr_n)
        tc_v[s] == stage_en[s+1]);
    end
  end

  assign carry_out = tc_v[STAGES-1];

  // R6: the wide terminal count implies the whole counter is all ones
  p_wide_tc_r6: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (&count && carry_en));

  // R4: an enabled step from all ones wraps the whole counter to zero
  p_wrap_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && gate_en && carry_out) |=> count == '0);
endmodule

// File: tb/cascade_counter_tb_top.sv
module cascade_counter_tb_top;
  localparam int SW = 4;
  localparam int NS = 2;
  localparam int TW = SW * NS;
  localparam logic [TW-1:0] ALL1 = '1;

  logic          clk = 1'b0;
  logic          clr_n = 1'b0;
  logic          load_n = 1'b1;
  logic          gate_en = 1'b0;
  logic          carry_en = 1'b0;
  logic [TW-1:0] load_val = '0;
  logic [TW-1:0] count;
  logic          carry_out;

  logic [TW-1:0] exp_q = '0;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cascade_counter #(.SLICE_W(SW), .STAGES(NS)) dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .gate_en(gate_en),
    .carry_en(carry_en), .load_val(load_val), .count(count), .carry_out(carry_out)
  );

  function automatic logic [TW-1:0] next_q(logic [TW-1:0] q, logic ld_n,
                                           logic g, logic c, logic [TW-1:0] d);
    if (!ld_n)      return d;
    else if (g && c) return q + TW'(1);
    else            return q;
  endfunction

  function automatic logic exp_tc(logic [TW-1:0] q, logic c);
    return c && (q == ALL1);
  endfunction

  task automatic check(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive after falling edge, check mid-cycle, then after rising edge
  task automatic cycle(logic ld_n, logic g, logic c, logic [TW-1:0] d);
    @(negedge clk);
    load_n = ld_n; gate_en = g; carry_en = c; load_val = d;
    #1;
    check("R1 count stable between edges", count, exp_q);
    check("R6 carry_out", TW'(carry_out), TW'(exp_tc(exp_q, c)));
    exp_q = next_q(exp_q, ld_n, g, c, d);
    @(posedge clk); #1;
    check("R3/R4/R5/R7 count after edge", count, exp_q);
  endtask

  task automatic mid_clear();
    @(negedge clk);
    load_n = 1'b0; gate_en = 1'b1; carry_en = 1'b1; load_val = 8'hA5;
    #2 clr_n = 1'b0;
    #1 check("R2 clear acts before edge", count, '0);
    @(posedge clk); #1;
    check("R2 clear overrides load", count, '0);
    #2 clr_n = 1'b1;
    exp_q = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 check("R2 reset state", count, '0);
    repeat (2) @(posedge clk);
    #2 clr_n = 1'b1;
    // R3: load with both enables low and with both high
    cycle(1'b0, 1'b0, 1'b0, 8'h3C);
    cycle(1'b0, 1'b1, 1'b1, 8'h0E);
    // R4/R7: cross the slice boundary 0x0F -> 0x10 -> 0x11
    repeat (3) cycle(1'b1, 1'b1, 1'b1, '0);
    // R5: each enable low alone holds
    cycle(1'b1, 1'b0, 1'b1, '0);
    cycle(1'b1, 1'b1, 1'b0, '0);
    // R6: all ones with carry low gives no terminal count, then high
    cycle(1'b0, 1'b0, 1'b0, ALL1);
    cycle(1'b1, 1'b1, 1'b0, '0);
    // R4: wrap all ones -> 0
    cycle(1'b1, 1'b1, 1'b1, '0);
    check("R4 wrapped to zero", count, '0);
    // R2: mid-cycle clear with load and enables active
    cycle(1'b0, 1'b0, 1'b0, 8'h77);
    mid_clear();
    // random mix
    for (int i = 0; i < 600; i++) begin
      automatic int r = int'($urandom_range(0, 99));
      automatic logic ld_n = (r >= 8);
      automatic logic g = ($urandom_range(0, 9) != 0);
      automatic logic c = ($urandom_range(0, 9) != 0);
      automatic logic [TW-1:0] d = (r < 4) ? TW'($urandom_range(250, 255)) : TW'($urandom);
      cycle(ld_n, g, c, d);
      if (i % 150 == 149) mid_clear();
    end
    done = 1;
    finish_run();
  end
endmodule